// File: doc/BRIEF.md
# DMA Destination Address Generator

This block is the destination-address unit of one DMA channel. Software loads and reads back a 32-bit destination pointer through a plain register port. During a transfer, each beat-done strobe moves the pointer by the transfer size, so the register always holds the address the next beat will use. The pointer can count up, count down or stay where it is.

The block checks the pointer against the alignment that the current transfer size needs and raises an error flag while it is misaligned. A flagged pointer does not move. The address driven to the bus is taken from the pointer. In 32-bit mode it passes through unchanged. In 29-bit mode the three top bits are rewritten according to the area the pointer names.

Top module: `dma_dst_addr_gen`

## Requirements
- R1: A write with `wr_en` high loads `wr_data` into the pointer at the clock edge, and `rd_data` shows the new value from that edge on.
- R2: With `inc_mode` = 1, each accepted `beat_done` adds the size step to the pointer. The step is 1, 2, 4, 16 or 32 bytes for `xfer_size` 0, 1, 2, 3 or 4 (byte, word, longword, 16-byte, 32-byte), and the sum wraps modulo 2^32.
- R3: With `inc_mode` = 2, each accepted `beat_done` subtracts the size step from the pointer.
- R4: With `inc_mode` = 0 or 3, `beat_done` leaves the pointer unchanged.
- R5: `align_err` is high in the same cycle whenever the pointer's low bits are not zero for the current size. The bits checked are none for a byte, bit 0 for a word, bits 1:0 for a longword, bits 3:0 for 16-byte and bits 4:0 for 32-byte.
- R6: A `xfer_size` value of 5, 6 or 7 is unsupported and holds `align_err` high.
- R7: While `align_err` is high, `beat_done` has no effect on the pointer.
- R8: When `wr_en` and `beat_done` are high in the same cycle, the written value is loaded and the beat is dropped.
- R9: With `mode29` low, `bus_addr` equals the pointer.
- R10: With `mode29` high and pointer bits 31:29 equal to 111, `bus_addr` equals the pointer.
- R11: With `mode29` high, pointer bits 31:29 not 111 and bits 28:26 (the area number) equal to 111, `bus_addr` is the pointer with bits 31:29 forced to 111.
- R12: With `mode29` high, bits 31:29 not 111 and an area number of 0 to 6, `bus_addr` is the pointer with bits 31:29 forced to 000. In every mode, `bus_addr` bits 28:0 match the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load the pointer from `wr_data` |
| wr_data | input | 32 | Value written to the pointer |
| rd_data | output | 32 | Current pointer value |
| xfer_size | input | 3 | 0 byte, 1 word, 2 longword, 3 16-byte, 4 32-byte |
| inc_mode | input | 2 | 0 fixed, 1 increment, 2 decrement, 3 fixed |
| beat_done | input | 1 | One transfer beat completed |
| mode29 | input | 1 | 1 selects 29-bit address mapping, 0 selects 32-bit pass-through |
| bus_addr | output | 32 | Address driven to the bus |
| align_err | output | 1 | Pointer misaligned for the current size, or size unsupported |

## Verification
A software write and a beat-done strobe can arrive in the same clock cycle. The bench provokes this by raising both strobes together, once on an aligned pointer and once right after a misaligned one. It then judges the result by reading back exactly the written value on the following cycle.

A second collision is a beat that arrives while the alignment flag is high. The bench issues a beat on a misaligned pointer and checks that the readback still holds the original value.

// File: rtl/dst_addr_pkg.sv
package dst_addr_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE = 3'd0,
    SZ_WORD = 3'd1,
    SZ_LONG = 3'd2,
    SZ_B16  = 3'd3,
    SZ_B32  = 3'd4
  } xfer_size_e;

  typedef enum logic [1:0] {
    INC_FIXED = 2'd0,
    INC_UP    = 2'd1,
    INC_DOWN  = 2'd2,
    INC_HOLD  = 2'd3
  } inc_mode_e;

  localparam int NUM_SIZES = 5;

  // log2 of the byte step for a size code (codes 3 and 4 skip 8 bytes)
  function automatic int unsigned size_shift(input logic [2:0] sz);
    return (sz < 3'd3) ? int'(sz) : int'(sz) + 1;
  endfunction
endpackage

// File: rtl/dst_align_chk.sv
module dst_align_chk
  import dst_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] ptr,
  input  logic [2:0]    size,
  output logic          err
);
  localparam int NS = NUM_SIZES;

  logic [NS-1:0] mis;

  for (genvar gi = 0; gi < NS; gi++) begin : g_size
    localparam int SH = (gi < 3) ? gi : gi + 1;
    localparam logic [AW-1:0] MASK = (AW'(1) << SH) - AW'(1);
    assign mis[gi] = |(ptr & MASK);
  end

  always_comb begin
    if (int'(size) < NS) err = mis[size];
    else                 err = 1'b1;
  end
endmodule

// File: rtl/dst_ptr_reg.sv
module dst_ptr_reg
  import dst_addr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic [2:0]    size,
  input  logic [1:0]    inc,
  input  logic          beat,
  input  logic          err,
  output logic [AW-1:0] ptr_q
);
  logic [AW-1:0] step;
  logic          take;

  assign step = (int'(size) < NUM_SIZES) ? (AW'(1) << size_shift(size)) : '0;
  assign take = beat && !err && !wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (wr_en) begin
      ptr_q <= wr_data;
    end else if (take) begin
      unique case (inc_mode_e'(inc))
        INC_UP:   ptr_q <= ptr_q + step;
        INC_DOWN: ptr_q <= ptr_q - step;
        default:  ptr_q <= ptr_q;
      endcase
    end
  end

  a_r1_write_loads: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ptr_q == $past(wr_data));
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (beat && !wr_en && !err && inc == 2'd1) |=> ptr_q == $past(ptr_q) + $past(step));
  a_r3_step_down: assert property (@(posedge clk) disable iff (rst)
    (beat && !wr_en && !err && inc == 2'd2) |=> ptr_q == $past(ptr_q) - $past(step));
  a_r7_err_blocks: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && err) |=> $stable(ptr_q));
endmodule

// File: rtl/dst_addr_xlate.sv
module dst_addr_xlate #(
  parameter int AW = 32
) (
  input  logic          mode29,
  input  logic [AW-1:0] ptr,
  output logic [AW-1:0] addr
);
  localparam int TOP_LSB  = AW - 3;
  localparam int AREA_LSB = AW - 6;

  logic [2:0] top_bits;
  logic [2:0] area;

  assign top_bits = ptr[AW-1:TOP_LSB];
  assign area     = ptr[TOP_LSB-1:AREA_LSB];

  always_comb begin
    addr = ptr;
    if (mode29 && top_bits != 3'b111) begin
      addr[AW-1:TOP_LSB] = (area == 3'b111) ? 3'b111 : 3'b000;
    end
  end
endmodule

// File: rtl/dma_dst_addr_gen.sv
module dma_dst_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] rd_data,
  input  logic [2:0]    xfer_size,
  input  logic [1:0]    inc_mode,
  input  logic          beat_done,
  input  logic          mode29,
  output logic [AW-1:0] bus_addr,
  output logic          align_err
);
  localparam int TOP_LSB = AW - 3;

  logic [AW-1:0] ptr_q;

  dst_align_chk #(.AW(AW)) u_align (
    .ptr  (ptr_q),
    .size (xfer_size),
    .err  (align_err)
  );

  dst_ptr_reg #(.AW(AW)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .size    (xfer_size),
    .inc     (inc_mode),
    .beat    (beat_done),
    .err     (align_err),
    .ptr_q   (ptr_q)
  );

  dst_addr_xlate #(.AW(AW)) u_xlate (
    .mode29 (mode29),
    .ptr    (ptr_q),
    .addr   (bus_addr)
  );

  assign rd_data = ptr_q;

  a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
    (wr_en && beat_done) |=> rd_data == $past(wr_data));
  a_r9_pass32: assert property (@(posedge clk) disable iff (rst)
    !mode29 |-> bus_addr == rd_data);
  a_r10_pass_top7: assert property (@(posedge clk) disable iff (rst)
    (mode29 && rd_data[AW-1:TOP_LSB] == 3'b111) |-> bus_addr == rd_data);
  a_r12_low_bits: assert property (@(posedge clk) disable iff (rst)
    bus_addr[TOP_LSB-1:0] == rd_data[TOP_LSB-1:0]);
  a_r6_bad_size: assert property (@(posedge clk) disable iff (rst)
    (xfer_size > 3'd4) |-> align_err);
endmodule

// File: tb/test_dma_dst_addr_gen.sv
module test_dma_dst_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [2:0]  xfer_size;
  logic [1:0]  inc_mode;
  logic        beat_done;
  logic        mode29;
  logic [31:0] bus_addr;
  logic        align_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_dst_addr_gen i_dma_dst_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .xfer_size(xfer_size), .inc_mode(inc_mode), .beat_done(beat_done),
    .mode29(mode29), .bus_addr(bus_addr), .align_err(align_err)
  );

  // {ptr, size, inc, mode29, exp_ptr, exp_bus, exp_err}
  localparam int NV = 24;
  localparam logic [102:0] VEC [NV] = '{
    {32'h0000_1000, 3'd2, 2'd1, 1'b0, 32'h0000_1004, 32'h0000_1004, 1'b0}, // R2
    {32'h0000_1000, 3'd0, 2'd1, 1'b0, 32'h0000_1001, 32'h0000_1001, 1'b0}, // R2
    {32'h0000_1000, 3'd1, 2'd1, 1'b0, 32'h0000_1002, 32'h0000_1002, 1'b0}, // R2
    {32'h0000_1000, 3'd3, 2'd1, 1'b0, 32'h0000_1010, 32'h0000_1010, 1'b0}, // R2
    {32'h0000_1000, 3'd4, 2'd1, 1'b0, 32'h0000_1020, 32'h0000_1020, 1'b0}, // R2
    {32'h0000_1000, 3'd2, 2'd2, 1'b0, 32'h0000_0FFC, 32'h0000_0FFC, 1'b0}, // R3
    {32'h0000_1000, 3'd4, 2'd2, 1'b0, 32'h0000_0FE0, 32'h0000_0FE0, 1'b0}, // R3
    {32'h0000_1000, 3'd2, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R4
    {32'h0000_1000, 3'd2, 2'd3, 1'b0, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R4
    {32'h0000_1002, 3'd2, 2'd1, 1'b0, 32'h0000_1002, 32'h0000_1002, 1'b1}, // R5 R7
    {32'h0000_1001, 3'd1, 2'd1, 1'b0, 32'h0000_1001, 32'h0000_1001, 1'b1}, // R5 R7
    {32'h0000_1008, 3'd3, 2'd1, 1'b0, 32'h0000_1008, 32'h0000_1008, 1'b1}, // R5 R7
    {32'h0000_1010, 3'd4, 2'd1, 1'b0, 32'h0000_1010, 32'h0000_1010, 1'b1}, // R5 R7
    {32'h0000_1003, 3'd0, 2'd1, 1'b0, 32'h0000_1004, 32'h0000_1004, 1'b0}, // R5 byte
    {32'h0000_1000, 3'd5, 2'd1, 1'b0, 32'h0000_1000, 32'h0000_1000, 1'b1}, // R6
    {32'h0000_1000, 3'd7, 2'd1, 1'b0, 32'h0000_1000, 32'h0000_1000, 1'b1}, // R6
    {32'hFFFF_FFFC, 3'd2, 2'd1, 1'b0, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R2 wrap
    {32'hE000_0100, 3'd2, 2'd0, 1'b1, 32'hE000_0100, 32'hE000_0100, 1'b0}, // R10
    {32'h1C00_0000, 3'd2, 2'd0, 1'b1, 32'h1C00_0000, 32'hFC00_0000, 1'b0}, // R11
    {32'h7C00_0040, 3'd2, 2'd0, 1'b1, 32'h7C00_0040, 32'hFC00_0040, 1'b0}, // R11
    {32'hA400_0020, 3'd2, 2'd0, 1'b1, 32'hA400_0020, 32'h0400_0020, 1'b0}, // R12
    {32'h8000_1000, 3'd2, 2'd1, 1'b1, 32'h8000_1004, 32'h0000_1004, 1'b0}, // R12
    {32'h5800_0000, 3'd2, 2'd0, 1'b1, 32'h5800_0000, 32'h1800_0000, 1'b0}, // R12
    {32'hA400_0020, 3'd2, 2'd0, 1'b0, 32'hA400_0020, 32'hA400_0020, 1'b0}  // R9
  };

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_ptr(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v; beat_done = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic beat_once();
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; xfer_size = 3'd2;
    inc_mode = 2'd1; beat_done = 1'b0; mode29 = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: first write after reset is read back on the next cycle
    write_ptr(32'h1234_5678);
    check32("R1 readback", rd_data, 32'h1234_5678);
    check32("R9 bus after write", bus_addr, 32'h1234_5678);

    // table walk: write, configure, one beat, check
    for (int i = 0; i < NV; i++) begin
      logic [102:0] v;
      v = VEC[i];
      write_ptr(v[102:71]);
      xfer_size = v[70:68]; inc_mode = v[67:66]; mode29 = v[65];
      beat_once();
      check32($sformatf("R2-table ptr v%0d", i), rd_data, v[64:33]);
      check32($sformatf("R11-table bus v%0d", i), bus_addr, v[32:1]);
      check1($sformatf("R5-table err v%0d", i), align_err, v[0]);
    end

    // R2: several consecutive beats
    mode29 = 1'b0; xfer_size = 3'd2; inc_mode = 2'd1;
    write_ptr(32'h0000_0100);
    for (int k = 0; k < 4; k++) beat_once();
    check32("R2 four beats", rd_data, 32'h0000_0110);

    // R8: write and beat in the same cycle on an aligned pointer
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_2000; beat_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; beat_done = 1'b0;
    check32("R8 write wins", rd_data, 32'h0000_2000);

    // R8: collision right after a misaligned pointer
    write_ptr(32'h0000_0003);
    check1("R5 misaligned long", align_err, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 32'h0000_3000; beat_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; beat_done = 1'b0;
    check32("R8 write wins over err", rd_data, 32'h0000_3000);
    check1("R5 realigned", align_err, 1'b0);

    // R7: repeated beats on a misaligned pointer do nothing
    xfer_size = 3'd3;
    write_ptr(32'h0000_3004);
    for (int k = 0; k < 3; k++) beat_once();
    check32("R7 held", rd_data, 32'h0000_3004);

    // R10 R11: mode switch is visible without a write
    write_ptr(32'h1C00_0010);
    mode29 = 1'b1; #1;
    check32("R11 mode flip", bus_addr, 32'hFC00_0010);
    mode29 = 1'b0; #1;
    check32("R9 mode flip back", bus_addr, 32'h1C00_0010);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule